// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block runs a serial EEPROM with 16-bit words and a 6-bit word address over a select line, a serial clock and one data wire in each direction. A client hands it one command at a time on a valid/ready handshake: a 3-bit command code, a word address and a write word. The controller builds the frame, divides the system clock down to the serial clock, and shifts the frame out. Reads return a 16-bit word. Each command finishes with a single-cycle completion strobe.

Four commands start a self-timed programming cycle in the memory: single-word write, single-word erase, erase-all and write-all. For each of these the controller drops select after the last bit and keeps it low for a fixed minimum. It then raises select again and watches the memory's output until the memory reports ready. If a cycle budget runs out first, the controller flags an error. It never retries and always returns to idle with select low.

The divider half-period, the select-low minimum and the poll budget are all counted in system clocks. They are set for the system clock rate, so that each serial clock phase lasts at least 250 ns and the full serial period lasts at least 1 µs.

Top module: `mw_host`

## Requirements
- R1: Command codes on `req_op` are READ=0, WRITE=1, ERASE=2, EN=3, DIS=4, ERASE_ALL=5, WRITE_ALL=6. Every frame opens with a 1 bit and then two opcode bits: READ 10, WRITE 01, ERASE 11, and 00 for the other four. Six address bits follow, most significant first. For EN, DIS, ERASE_ALL and WRITE_ALL the address is replaced by a fixed pattern whose top two bits are 11, 00, 10 and 01 respectively, with the low four bits 0.
- R2: WRITE and WRITE_ALL add the 16 data bits after the address, most significant first, for 25 serial clock rising edges in all.
- R3: While select is high, every serial clock phase lasts exactly `HALF_DIV` system clocks. The first low phase is measured from the rise of select. The serial output changes only together with a falling serial clock edge, so it holds steady across each rising edge.
- R4: READ drives the serial output low after the address and runs 26 rising edges. The bit sampled at the tenth rising edge is the dummy 0 and is discarded. The next 16 sampled bits appear on `rsp_rdata`, first bit in the top position, when the completion strobe fires.
- R5: After a programming command, select falls on the falling serial clock edge that follows the last frame bit. It stays low for exactly `CSLOW_CYC` system clocks and then rises to poll status.
- R6: During the poll, a 1 on `ser_in` ends the command: select goes low and the strobe fires with `rsp_err` low.
- R7: If `ser_in` stays 0 for `TIMEOUT_CYC` poll cycles, the strobe fires with `rsp_err` high and select returns low.
- R8: READ, EN and DIS do not poll. Select drops on the falling edge after the frame, and the strobe fires on that same cycle.
- R9: `req_ready` is high only in idle. A request offered at any other time is not taken, and select and the serial clock stay low in idle.
- R10: After reset, select, serial clock and serial output are low, `req_ready` is high and the strobe is low.
- R11: `rsp_done` lasts one cycle per command, and `rsp_err` is never high without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command request present |
| req_ready | output | 1 | Controller idle and able to take a command |
| req_op | input | 3 | Command code (see R1) |
| req_addr | input | 6 | Word address |
| req_wdata | input | 16 | Word for WRITE / WRITE_ALL |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_err | output | 1 | Poll budget ran out (with `rsp_done`) |
| rsp_rdata | output | 16 | Word read by the last READ |
| ser_sel | output | 1 | Memory select, active high |
| ser_clk | output | 1 | Serial clock |
| ser_out | output | 1 | Serial data to the memory |
| ser_in | input | 1 | Serial data / ready status from the memory |

## Verification
The bench models the memory. It answers a read with a leading 0 and then the word, so a controller that failed to drop the dummy bit would return every word shifted down one place and lose its last bit. Test words with set end bits (8001, A5C3) expose any off-by-one in the capture window or in the opcode and data boundary. The memory model holds status busy for a number of cycles, once briefly and once beyond the budget. A controller that raised select too early would show the wrong select-low gap, and one that ignored the budget would never reach the error strobe. Phase lengths and serial output changes are measured on every edge of every frame, which catches a divider or shift register that moves data while the clock is high.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        OP_READ      = 3'd0,
        OP_WRITE     = 3'd1,
        OP_ERASE     = 3'd2,
        OP_EN        = 3'd3,
        OP_DIS       = 3'd4,
        OP_ERASE_ALL = 3'd5,
        OP_WRITE_ALL = 3'd6
    } mw_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_CSLOW,
        ST_POLL
    } mw_state_e;

    localparam int HDR_W   = 9;
    localparam int WORD_W  = 16;
    localparam int FRAME_W = HDR_W + WORD_W;
    localparam int RISE_W  = 5;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [RISE_W-1:0]  rises;
        logic               is_read;
        logic               is_prog;
    } mw_frame_t;

    function automatic mw_frame_t build_frame(logic [2:0] op, logic [5:0] a,
                                              logic [WORD_W-1:0] d);
        mw_frame_t          f;
        logic [HDR_W-1:0]   hdr;
        logic [WORD_W-1:0]  tail;
        f    = '0;
        tail = '0;
        f.rises = RISE_W'(HDR_W);
        case (mw_op_e'(op))
            OP_READ: begin
                hdr = {3'b110, a};
                f.rises = RISE_W'(HDR_W + WORD_W + 1);
                f.is_read = 1'b1;
            end
            OP_WRITE: begin
                hdr = {3'b101, a};
                tail = d;
                f.rises = RISE_W'(FRAME_W);
                f.is_prog = 1'b1;
            end
            OP_ERASE: begin
                hdr = {3'b111, a};
                f.is_prog = 1'b1;
            end
            OP_EN:        hdr = 9'b100_110000;
            OP_ERASE_ALL: begin
                hdr = 9'b100_100000;
                f.is_prog = 1'b1;
            end
            OP_WRITE_ALL: begin
                hdr = 9'b100_010000;
                tail = d;
                f.rises = RISE_W'(FRAME_W);
                f.is_prog = 1'b1;
            end
            default:      hdr = 9'b100_000000;
        endcase
        f.bits = {hdr, tail};
        return f;
    endfunction

endpackage

// File: rtl/mw_sk_gen.sv
module mw_sk_gen #(
    parameter int HALF_DIV = 63
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic sk,
    output logic rise,
    output logic fall
);
    localparam int CW = $clog2(HALF_DIV + 1);

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = en && (cnt == CW'(HALF_DIV - 1));
    assign rise = tick && !sk;
    assign fall = tick && sk;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            sk  <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            sk  <= ~sk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3
    sk_parked_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !sk);

endmodule

// File: rtl/mw_cycle_timer.sv
module mw_cycle_timer #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic last
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign last = run && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (!last)  cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/mw_host.sv
module mw_host
    import mw_pkg::*;
#(
    parameter int HALF_DIV    = 63,
    parameter int CSLOW_CYC   = 32,
    parameter int TIMEOUT_CYC = 1250000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [2:0]  req_op,
    input  logic [5:0]  req_addr,
    input  logic [15:0] req_wdata,
    output logic        rsp_done,
    output logic        rsp_err,
    output logic [15:0] rsp_rdata,
    output logic        ser_sel,
    output logic        ser_clk,
    output logic        ser_out,
    input  logic        ser_in
);
    localparam int PH_W      = $clog2(HALF_DIV + 1);
    localparam int DUMMY_IDX = HDR_W + 1;

    mw_state_e         state;
    mw_frame_t         frm, new_frm;
    logic [RISE_W-1:0] rise_cnt;
    logic              sk_rise, sk_fall, cslow_last, poll_last;

    assign new_frm   = build_frame(req_op, req_addr, req_wdata);
    assign req_ready = (state == ST_IDLE);

    mw_sk_gen #(.HALF_DIV(HALF_DIV)) u_sk (
        .clk(clk), .rst(rst), .en(state == ST_SHIFT),
        .sk(ser_clk), .rise(sk_rise), .fall(sk_fall)
    );

    mw_cycle_timer #(.LIMIT(CSLOW_CYC)) u_cslow (
        .clk(clk), .rst(rst), .run(state == ST_CSLOW), .last(cslow_last)
    );

    mw_cycle_timer #(.LIMIT(TIMEOUT_CYC)) u_poll (
        .clk(clk), .rst(rst), .run(state == ST_POLL), .last(poll_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            frm       <= '0;
            rise_cnt  <= '0;
            rsp_rdata <= '0;
            rsp_done  <= 1'b0;
            rsp_err   <= 1'b0;
            ser_sel   <= 1'b0;
            ser_out   <= 1'b0;
        end else begin
            rsp_done <= 1'b0;
            rsp_err  <= 1'b0;
            case (state)
                ST_IDLE: if (req_valid) begin
                    frm      <= new_frm;
                    ser_out  <= new_frm.bits[FRAME_W-1];
                    ser_sel  <= 1'b1;
                    rise_cnt <= '0;
                    state    <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (sk_rise) begin
                        rise_cnt <= rise_cnt + 1'b1;
                        if (frm.is_read && rise_cnt >= RISE_W'(DUMMY_IDX))
                            rsp_rdata <= {rsp_rdata[14:0], ser_in};
                    end
                    if (sk_fall) begin
                        if (rise_cnt == frm.rises) begin
                            ser_out  <= 1'b0;
                            ser_sel  <= 1'b0;
                            rsp_done <= !frm.is_prog;
                            state    <= frm.is_prog ? ST_CSLOW : ST_IDLE;
                        end else begin
                            frm.bits <= frm.bits << 1;
                            ser_out  <= frm.bits[FRAME_W-2];
                        end
                    end
                end
                ST_CSLOW: if (cslow_last) begin
                    ser_sel <= 1'b1;
                    state   <= ST_POLL;
                end
                ST_POLL: if (ser_in || poll_last) begin
                    ser_sel  <= 1'b0;
                    rsp_done <= 1'b1;
                    rsp_err  <= !ser_in;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Phase-length checker: cycles since the serial clock or select last changed.
    logic            sk_prev, sel_prev;
    logic [PH_W-1:0] phase_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sk_prev   <= 1'b0;
            sel_prev  <= 1'b0;
            phase_cnt <= '0;
        end else begin
            sk_prev  <= ser_clk;
            sel_prev <= ser_sel;
            if (ser_clk != sk_prev || (ser_sel && !sel_prev))
                phase_cnt <= PH_W'(1);
            else if (phase_cnt < PH_W'(HALF_DIV))
                phase_cnt <= phase_cnt + 1'b1;
        end
    end

    // R3
    sk_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (ser_clk != sk_prev) |-> (phase_cnt >= PH_W'(HALF_DIV)));

    // R3
    di_steady_high_chk: assert property (@(posedge clk) disable iff (rst)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_out));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!ser_sel && !ser_clk));

    // R9
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (ser_sel && !req_ready));

    // R5
    sel_drop_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_sel) |-> !ser_clk);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    // R11
    err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_done);

endmodule

// File: tb/mw_host_test.sv
module mw_host_test;
    import mw_pkg::*;

    localparam int HD  = 2;
    localparam int CSL = 4;
    localparam int TMO = 200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = '0;
    logic [5:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_done, rsp_err;
    logic [15:0] rsp_rdata;
    logic        ser_sel, ser_clk, ser_out, ser_in;

    always #4 clk = ~clk;

    mw_host #(.HALF_DIV(HD), .CSLOW_CYC(CSL), .TIMEOUT_CYC(TMO)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .ser_sel(ser_sel), .ser_clk(ser_clk), .ser_out(ser_out), .ser_in(ser_in)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [15:0] mem [64];
    logic        wen, sel_d, sk_d, rd_mode, rd_bit;
    logic [31:0] sh, last_frame;
    logic [15:0] rd_word;
    int          nb, last_nb, busy, gap, last_gap;
    int          busy_len = 30;

    assign ser_in = !ser_sel ? 1'b0 : rd_mode ? rd_bit : (busy == 0);

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) mem[i] <= 16'(i * 3);
            wen <= 0; sel_d <= 0; sk_d <= 0; rd_mode <= 0; rd_bit <= 0;
            sh <= '0; last_frame <= '0; rd_word <= '0;
            nb <= 0; last_nb <= 0; busy <= 0; gap <= 0; last_gap <= 0;
        end else begin
            logic [8:0] f;
            sel_d <= ser_sel;
            sk_d  <= ser_clk;
            if (busy > 0) busy <= busy - 1;
            if (ser_sel && !sel_d) begin
                nb <= 0; sh <= '0; rd_mode <= 0; last_gap <= gap;
            end else if (ser_sel && ser_clk && !sk_d) begin
                f = {sh[7:0], ser_out};
                sh <= {sh[30:0], ser_out};
                nb <= nb + 1;
                if (nb == 8 && f[7:6] == 2'b10) begin
                    rd_mode <= 1; rd_bit <= 0; rd_word <= mem[f[5:0]];
                end else if (rd_mode) begin
                    rd_bit <= rd_word[15]; rd_word <= {rd_word[14:0], 1'b0};
                end
            end
            if (!ser_sel && sel_d) begin
                gap <= 1;
                if (nb != 0) begin
                    last_frame <= sh;
                    last_nb    <= nb;
                    if (nb == 9 && sh[7:6] == 2'b00) begin
                        if (sh[5:4] == 2'b11) wen <= 1;
                        if (sh[5:4] == 2'b00) wen <= 0;
                        if (sh[5:4] == 2'b10 && wen) begin
                            for (int i = 0; i < 64; i++) mem[i] <= 16'hFFFF;
                            busy <= busy_len;
                        end
                    end else if (nb == 9 && sh[7:6] == 2'b11 && wen) begin
                        mem[sh[5:0]] <= 16'hFFFF; busy <= busy_len;
                    end else if (nb == 25 && wen && sh[23:22] == 2'b01) begin
                        mem[sh[21:16]] <= sh[15:0]; busy <= busy_len;
                    end else if (nb == 25 && wen && sh[23:20] == 4'b0001) begin
                        for (int i = 0; i < 64; i++) mem[i] <= sh[15:0];
                        busy <= busy_len;
                    end
                end
            end else if (!ser_sel) begin
                gap <= gap + 1;
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic        err;
        logic        chk_rd;
        logic [15:0] rd;
        string       req;
    } exp_t;
    exp_t q[$];

    always @(negedge clk) begin
        if (!rst && rsp_done) begin
            exp_t e;
            if (q.size() == 0) begin
                chk(0, "R11", "unexpected done", 1, 0);
            end else begin
                e = q.pop_front();
                chk(rsp_err == e.err, e.req, "err", 32'(rsp_err), 32'(e.err));
                if (e.chk_rd)
                    chk(rsp_rdata == e.rd, e.req, "rdata", 32'(rsp_rdata), 32'(e.rd));
            end
        end
    end

    // ---------------- phase / data-change monitor (R3) ----------------
    int   ph = 0, phase_bad = 0, di_bad = 0, phases = 0;
    logic skp = 0, dip = 0, selp = 0;

    always @(negedge clk) begin
        if (ser_sel && !selp) ph = 1;
        else if (ser_clk == skp) ph++;
        else begin
            if (ser_sel && selp) begin
                phases++;
                if (ph != HD) phase_bad++;
            end
            ph = 1;
        end
        if (ser_sel && selp && ser_out != dip && !(skp && !ser_clk)) di_bad++;
        skp = ser_clk; dip = ser_out; selp = ser_sel;
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=done", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- driver ----------------
    task automatic run_cmd(mw_op_e op, logic [5:0] a, logic [15:0] d,
                           logic e_err, logic c_rd, logic [15:0] e_rd, string req);
        exp_t e;
        e.err = e_err; e.chk_rd = c_rd; e.rd = e_rd; e.req = req;
        q.push_back(e);
        @(negedge clk);
        req_valid = 1; req_op = op; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        while (!rsp_done) @(negedge clk);
        @(negedge clk);
        chk(rsp_done == 0, "R11", "done width", 32'(rsp_done), 0);
    endtask

    task automatic chk_frame(logic [31:0] exp_bits, int exp_nb, string req);
        chk(last_nb == exp_nb, req, "rise count", 32'(last_nb), 32'(exp_nb));
        chk(last_frame == exp_bits, req, "frame bits", last_frame, exp_bits);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10
        chk(ser_sel == 0 && ser_clk == 0 && ser_out == 0, "R10", "serial lines",
            {29'd0, ser_sel, ser_clk, ser_out}, 0);
        chk(req_ready == 1 && rsp_done == 0, "R10", "ready/done",
            {30'd0, req_ready, rsp_done}, 32'd2);

        // R1 R8: enable command, no poll
        run_cmd(OP_EN, 6'd0, 16'h0, 0, 0, 0, "R8");
        chk_frame(32'b1_00_110000, 9, "R1");
        chk(ser_sel == 0, "R8", "sel after frame", 32'(ser_sel), 0);

        // R2 R5 R6: write with poll
        run_cmd(OP_WRITE, 6'd5, 16'hA5C3, 0, 0, 0, "R6");
        chk_frame({7'd0, 3'b101, 6'd5, 16'hA5C3}, 25, "R2");
        chk(last_gap == CSL, "R5", "select-low gap", 32'(last_gap), 32'(CSL));

        // R4 reads
        run_cmd(OP_READ, 6'd5, 16'h0, 0, 1, 16'hA5C3, "R4");
        chk_frame({6'd0, 3'b110, 6'd5, 17'd0}, 26, "R4");
        run_cmd(OP_WRITE, 6'd62, 16'h8001, 0, 0, 0, "R6");
        run_cmd(OP_READ, 6'd62, 16'h0, 0, 1, 16'h8001, "R4");
        run_cmd(OP_READ, 6'd10, 16'h0, 0, 1, 16'd30, "R4");

        // R1 erase
        run_cmd(OP_ERASE, 6'd5, 16'h0, 0, 0, 0, "R6");
        chk_frame(32'b1_11_000101, 9, "R1");
        run_cmd(OP_READ, 6'd5, 16'h0, 0, 1, 16'hFFFF, "R4");

        // R2 write-all
        run_cmd(OP_WRITE_ALL, 6'd0, 16'h3C5A, 0, 0, 0, "R6");
        chk_frame({7'd0, 9'b1_00_010000, 16'h3C5A}, 25, "R2");
        run_cmd(OP_READ, 6'd33, 16'h0, 0, 1, 16'h3C5A, "R4");

        // R1 erase-all
        run_cmd(OP_ERASE_ALL, 6'd0, 16'h0, 0, 0, 0, "R6");
        chk_frame(32'b1_00_100000, 9, "R1");
        run_cmd(OP_READ, 6'd0, 16'h0, 0, 1, 16'hFFFF, "R4");

        // R1 disable, then a write the memory ignores
        run_cmd(OP_DIS, 6'd0, 16'h0, 0, 0, 0, "R8");
        chk_frame(32'b1_00_000000, 9, "R1");

        // R9: request held while the controller is busy
        fork
            run_cmd(OP_WRITE, 6'd1, 16'h1234, 0, 0, 0, "R6");
            begin
                repeat (12) @(negedge clk);
                chk(req_ready == 0, "R9", "ready while busy", 32'(req_ready), 0);
                chk(ser_sel == 1, "R9", "select while busy", 32'(ser_sel), 1);
            end
        join
        run_cmd(OP_READ, 6'd1, 16'h0, 0, 1, 16'hFFFF, "R4");

        // R7: memory never becomes ready
        run_cmd(OP_EN, 6'd0, 16'h0, 0, 0, 0, "R8");
        busy_len = 100000;
        run_cmd(OP_WRITE, 6'd3, 16'h5555, 1, 0, 0, "R7");
        chk(ser_sel == 0, "R7", "select after timeout", 32'(ser_sel), 0);
        chk(req_ready == 1, "R7", "idle after timeout", 32'(req_ready), 1);

        // R3 measured over all frames
        chk(phases > 100, "R3", "phases seen", 32'(phases), 101);
        chk(phase_bad == 0, "R3", "phase length errors", 32'(phase_bad), 0);
        chk(di_bad == 0, "R3", "data change outside falling edge", 32'(di_bad), 0);
        chk(q.size() == 0, "R11", "missing strobes", 32'(q.size()), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule